// File: doc/BRIEF.md
# Dual-FIFO Card Clock Flow Controller

This block moves block data between a CPU-side byte register and a memory card data bus. Bytes pass through two 8-byte FIFOs used in ping-pong fashion. The producer fills FIFO 0, then FIFO 1, then wraps back. The consumer drains them in the same order. In transmit, the CPU writes bytes and the card side takes one byte per card clock cycle. In receive, the card side delivers one byte per card clock cycle and the CPU reads them.

The card side is modelled as a byte-wide port with a one-cycle strobe. The block drives the card clock itself. With flow control on, it stops that clock whenever the buffers cannot take or supply another byte, and restarts it once a whole FIFO is ready again. The bus then freezes mid-block and waits for the CPU, however slow the CPU is.

A clock stop or start only ever takes effect during the low phase of the card clock. The card therefore never sees a truncated pulse.

Top module: `cardflow_ctrl`

## Requirements
- R1: After reset, and on every clock edge while `xfer_en` is low, both FIFOs are emptied, both error flags are cleared and the clock stop state is set. CPU accesses made while `xfer_en` is low are ignored, and the card clock settles low.
- R2: Bytes reach the consumer in the order the producer supplied them. `cpu_rdata` and `card_tx_data` always show the oldest buffered byte.
- R3: `fifo_empty[k]` is 1 exactly when FIFO k (buffer slots 8k to 8k+7) holds no byte. `fifo_full[k]` is 1 exactly when it holds 8 bytes. The producer fills slot 0 first and then moves through the 16 slots in ascending order, wrapping around.
- R4: `irq_full[k]` equals `fifo_full[k]` while `full_irq_mask[k]` is 0, and is 0 while that mask bit is 1.
- R5: A running card clock spends exactly CLK_DIV cycles high per period. `card_strobe` pulses for one cycle, in the last low cycle before each rising edge, and exactly one byte moves on each strobe.
- R6: In transmit (`dir_rx`=0) with `flow_en`=1, the card clock stops once both FIFOs are empty. It stays stopped until either FIFO is full.
- R7: In receive (`dir_rx`=1) with `flow_en`=1, the card clock stops once both FIFOs are full. It stays stopped until either FIFO is empty.
- R8: With `flow_en`=0 and `xfer_en`=1, the card clock runs continuously with period 2*CLK_DIV.
- R9: The clock is only ever stopped while low. Every low phase, including the first one after a restart, lasts at least CLK_DIV cycles.
- R10: A CPU write in transmit while all 16 slots are occupied is dropped and sets `err_ovr`. The flag stays set until `xfer_en` goes low.
- R11: A CPU read in receive while no byte is buffered is ignored and sets `err_udr`. The flag stays set until `xfer_en` goes low.
- R12: The following have no effect on the buffer or on the error flags: a CPU write in receive, a CPU read in transmit, a card strobe in transmit with nothing buffered, and a card strobe in receive with all slots full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_en | input | 1 | Block transfer enable; low flushes the buffer |
| dir_rx | input | 1 | 1 = receive from card, 0 = transmit to card |
| flow_en | input | 1 | Enables card clock gating |
| full_irq_mask | input | 2 | Per-FIFO full-interrupt mask, 1 = suppressed |
| cpu_wr | input | 1 | CPU write strobe for the data register |
| cpu_wdata | input | DATA_W | CPU write byte |
| cpu_rd | input | 1 | CPU read strobe for the data register |
| cpu_rdata | output | DATA_W | Oldest buffered byte |
| card_clk | output | 1 | Gated card bus clock |
| card_strobe | output | 1 | One-cycle byte transfer strobe for the serializer |
| card_tx_data | output | DATA_W | Byte offered to the card |
| card_rx_data | input | DATA_W | Byte delivered by the card |
| fifo_empty | output | 2 | Per-FIFO empty flags |
| fifo_full | output | 2 | Per-FIFO full flags |
| irq_full | output | 2 | Per-FIFO full interrupts after masking |
| err_ovr | output | 1 | Sticky CPU overrun flag |
| err_udr | output | 1 | Sticky CPU underrun flag |

## Verification
A CPU access and a card strobe can land in the same cycle. One case is a transmit write arriving while the card consumes the oldest byte. The other is a receive read arriving while the card delivers a new byte. Both cases are provoked with back-to-back bursts that are longer than the buffer while the card clock is running: 24 writes in transmit and 30 reads in receive. The burst also crosses the full and empty boundaries, so the same cycle sometimes carries a rejected access. A behavioural queue model, updated every cycle, then judges each outcome. It checks the byte order, both flag pairs and the error flags, and so shows whether both transfers were applied and whether a rejected access was dropped cleanly.

// File: rtl/cardflow_ctrl.sv
module cardflow_ctrl #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int CLK_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_en,
  input  logic              dir_rx,
  input  logic              flow_en,
  input  logic [1:0]        full_irq_mask,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              card_clk,
  output logic              card_strobe,
  output logic [DATA_W-1:0] card_tx_data,
  input  logic [DATA_W-1:0] card_rx_data,
  output logic [1:0]        fifo_empty,
  output logic [1:0]        fifo_full,
  output logic [1:0]        irq_full,
  output logic              err_ovr,
  output logic              err_udr
);

  localparam int ENTRIES = 2 * FIFO_DEPTH;
  localparam int PW      = $clog2(ENTRIES);
  localparam int HW      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [PW-1:0] LAST  = PW'(ENTRIES - 1);
  localparam logic [HW-1:0] HLAST = HW'(CLK_DIV - 1);

  logic [DATA_W-1:0]  mem [ENTRIES];
  logic [ENTRIES-1:0] valid;
  logic [PW-1:0]      wp, rp;
  logic               stalled, clk_q;
  logic [HW-1:0]      hcnt;
  logic               ovr_q, udr_q;

  for (genvar k = 0; k < 2; k++) begin : g_half
    assign fifo_full[k]  = &valid[k*FIFO_DEPTH +: FIFO_DEPTH];
    assign fifo_empty[k] = ~|valid[k*FIFO_DEPTH +: FIFO_DEPTH];
  end

  assign irq_full = fifo_full & ~full_irq_mask;

  wire run_req = xfer_en & (~flow_en | ~stalled);
  assign card_strobe = ~clk_q & run_req & (hcnt == HLAST);
  assign card_clk = clk_q;

  wire tx        = ~dir_rx;
  wire wr_try    = xfer_en & tx & cpu_wr;
  wire rd_try    = xfer_en & dir_rx & cpu_rd;
  wire slot_used = valid[wp];
  wire head_ok   = valid[rp];

  wire push = (wr_try & ~slot_used) | (card_strobe & dir_rx & ~slot_used);
  wire pop  = (rd_try & head_ok) | (card_strobe & tx & head_ok);
  wire [DATA_W-1:0] push_data = dir_rx ? card_rx_data : cpu_wdata;

  wire stall_set = tx ? (&fifo_empty) : (&fifo_full);
  wire stall_clr = tx ? (|fifo_full)  : (|fifo_empty);

  assign cpu_rdata    = mem[rp];
  assign card_tx_data = mem[rp];
  assign err_ovr      = ovr_q;
  assign err_udr      = udr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      wp    <= '0;
      rp    <= '0;
    end else if (!xfer_en) begin
      valid <= '0;
      wp    <= '0;
      rp    <= '0;
    end else begin
      if (push) begin
        valid[wp] <= 1'b1;
        wp        <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (pop) begin
        valid[rp] <= 1'b0;
        rp        <= (rp == LAST) ? '0 : rp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      stalled <= 1'b1;
    else if (!xfer_en)               stalled <= 1'b1;
    else if (stalled && stall_clr)   stalled <= 1'b0;
    else if (!stalled && stall_set)  stalled <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      hcnt  <= '0;
    end else if (!clk_q) begin
      if (!run_req)            hcnt <= '0;
      else if (hcnt == HLAST) begin
        clk_q <= 1'b1;
        hcnt  <= '0;
      end else                 hcnt <= hcnt + 1'b1;
    end else begin
      if (hcnt == HLAST) begin
        clk_q <= 1'b0;
        hcnt  <= '0;
      end else                 hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else if (!xfer_en) begin
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      if (wr_try && slot_used) ovr_q <= 1'b1;
      if (rd_try && !head_ok)  udr_q <= 1'b1;
    end
  end

  // R9
  clk_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> $past(run_req));

  // R6
  tx_no_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_strobe && !dir_rx && flow_en) |-> (fifo_empty != 2'b11));

  // R7
  rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_strobe && dir_rx && flow_en) |-> (fifo_full != 2'b11));

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovr && xfer_en) |=> err_ovr);

  // R11
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_udr && xfer_en) |=> err_udr);

  // R1
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> (fifo_empty == 2'b11 && !err_ovr && !err_udr));

endmodule

// File: tb/cardflow_ctrl_tb_top.sv
`timescale 1ns/100ps
module cardflow_ctrl_tb_top;
  localparam int DW = 8, DEPTH = 8, DIV = 2, N = 2 * DEPTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0, xfer_en = 1'b0, dir_rx = 1'b0, flow_en = 1'b0;
  logic [1:0] mask = 2'b00;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [DW-1:0] cpu_wdata = '0, card_rx_data = 8'h11;
  logic [DW-1:0] cpu_rdata, card_tx_data;
  logic card_clk, card_strobe, err_ovr, err_udr;
  logic [1:0] fifo_empty, fifo_full, irq_full;

  cardflow_ctrl #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .dir_rx(dir_rx), .flow_en(flow_en),
    .full_irq_mask(mask), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .cpu_rdata(cpu_rdata), .card_clk(card_clk), .card_strobe(card_strobe),
    .card_tx_data(card_tx_data), .card_rx_data(card_rx_data), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .irq_full(irq_full), .err_ovr(err_ovr), .err_udr(err_udr));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, rises = 0, run_len = DIV;
  logic prev_clk = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: a byte queue held as ring storage plus counters
  logic [DW-1:0] m_mem [N];
  int m_cnt = 0, m_rp = 0, m_ph = 0;
  bit m_st = 1, m_clk = 0, m_ovr = 0, m_udr = 0;

  function automatic int occ(int k);
    int n = 0;
    for (int i = 0; i < m_cnt; i++) if (((m_rp + i) % N) / DEPTH == k) n++;
    return n;
  endfunction

  always @(posedge clk) begin
    #1 card_rx_data <= card_rx_data + 8'd37;
  end

  always @(negedge clk) begin
    bit want, strb, wr, rd;
    logic [1:0] e_emp, e_full;
    int pre;
    logic [DW-1:0] wdat;
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (!rst_n) begin
      m_cnt = 0; m_rp = 0; m_ph = 0; m_st = 1; m_clk = 0; m_ovr = 0; m_udr = 0;
    end
    want = xfer_en && (!flow_en || !m_st);
    strb = !m_clk && want && (m_ph == DIV - 1);
    for (int k = 0; k < 2; k++) begin
      e_emp[k]  = (occ(k) == 0);
      e_full[k] = (occ(k) == DEPTH);
    end
    chk(card_clk === m_clk, "R5", "card_clk", card_clk, m_clk);
    chk(card_strobe === strb, "R5", "card_strobe", card_strobe, strb);
    chk(fifo_empty === e_emp, "R3", "fifo_empty", fifo_empty, e_emp);
    chk(fifo_full === e_full, "R3", "fifo_full", fifo_full, e_full);
    chk(irq_full === (e_full & ~mask), "R4", "irq_full", irq_full, e_full & ~mask);
    chk(err_ovr === m_ovr, "R10", "err_ovr", err_ovr, m_ovr);
    chk(err_udr === m_udr, "R11", "err_udr", err_udr, m_udr);
    if (m_cnt > 0) begin
      chk(cpu_rdata === m_mem[m_rp], "R2", "cpu_rdata", cpu_rdata, m_mem[m_rp]);
      chk(card_tx_data === m_mem[m_rp], "R2", "card_tx_data", card_tx_data, m_mem[m_rp]);
    end
    // clock phase monitor
    if (!rst_n) run_len = DIV;
    else if (card_clk !== prev_clk) begin
      if (prev_clk) chk(run_len == DIV, "R5", "high phase length", run_len, DIV);
      else begin
        chk(run_len >= DIV, "R9", "low phase length", run_len, DIV);
        rises++;
      end
      run_len = 1;
    end else run_len++;
    prev_clk = card_clk;
    if (rst_n) begin
      if (!xfer_en) begin
        m_cnt = 0; m_rp = 0; m_ovr = 0; m_udr = 0; m_st = 1;
      end else begin
        pre = m_cnt;
        if (!dir_rx) begin
          wr = cpu_wr && pre < N; rd = strb && pre > 0; wdat = cpu_wdata;
          if (cpu_wr && pre == N) m_ovr = 1;
        end else begin
          wr = strb && pre < N; rd = cpu_rd && pre > 0; wdat = card_rx_data;
          if (cpu_rd && pre == 0) m_udr = 1;
        end
        if (wr) m_mem[(m_rp + pre) % N] = wdat;
        if (rd) m_rp = (m_rp + 1) % N;
        m_cnt = pre + int'(wr) - int'(rd);
        if (!dir_rx) begin
          if (m_st && (e_full != 2'b00)) m_st = 0;
          else if (!m_st && e_emp == 2'b11) m_st = 1;
        end else begin
          if (m_st && (e_emp != 2'b00)) m_st = 0;
          else if (!m_st && e_full == 2'b11) m_st = 1;
        end
      end
      if (!m_clk) begin
        if (!want) m_ph = 0;
        else if (m_ph == DIV - 1) begin m_clk = 1; m_ph = 0; end
        else m_ph++;
      end else begin
        if (m_ph == DIV - 1) begin m_clk = 0; m_ph = 0; end
        else m_ph++;
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_byte(input logic [DW-1:0] b);
    cpu_wr = 1'b1; cpu_wdata = b; step(); cpu_wr = 1'b0;
  endtask

  task automatic rd_byte();
    cpu_rd = 1'b1; step(); cpu_rd = 1'b0;
  endtask

  task automatic flush();
    xfer_en = 1'b0; step(2 * DIV + 1);
  endtask

  initial begin
    int r0;
    step(3);
    // R1 reset state
    chk(fifo_empty == 2'b11 && fifo_full == 2'b00, "R1", "flags in reset", {fifo_empty, fifo_full}, 4'b1100);
    chk(card_clk == 1'b0 && !err_ovr && !err_udr, "R1", "clk/errors in reset", {card_clk, err_ovr, err_udr}, 0);
    rst_n = 1'b1;
    step(2);

    // transmit with flow control
    dir_rx = 1'b0; flow_en = 1'b1; mask = 2'b10; xfer_en = 1'b1;
    r0 = rises; step(20);
    chk(rises == r0, "R6", "rises while both empty", rises - r0, 0);
    for (int i = 0; i < 24; i++) wr_byte(DW'(i * 3 + 1));
    chk(err_ovr == 1'b1, "R10", "overrun after 24-byte burst", err_ovr, 1);
    for (int i = 0; i < 300 && fifo_empty != 2'b11; i++) step();
    step(10); r0 = rises; step(30);
    chk(rises == r0, "R6", "rises after drain", rises - r0, 0);
    chk(err_ovr == 1'b1, "R10", "overrun stays set", err_ovr, 1);
    flush();
    chk(!err_ovr && fifo_empty == 2'b11 && card_clk == 1'b0, "R1", "flush clears", {err_ovr, fifo_empty, card_clk}, 3'b011 << 1);
    cpu_wr = 1'b1; step(3); cpu_wr = 1'b0;
    chk(fifo_empty == 2'b11 && !err_ovr, "R1", "writes ignored while disabled", {fifo_empty, err_ovr}, 3'b110);
    xfer_en = 1'b1;
    for (int i = 0; i < 5; i++) wr_byte(DW'(8'h40 + i));
    r0 = rises; step(20);
    chk(rises == r0, "R6", "no restart on partial fill", rises - r0, 0);
    for (int i = 0; i < 3; i++) wr_byte(DW'(8'h50 + i));
    chk(fifo_full == 2'b01, "R3", "fifo0 full after 8 writes", fifo_full, 1);
    r0 = rises; step(15);
    chk(rises > r0, "R6", "restart once fifo0 full", rises - r0, 1);
    cpu_rd = 1'b1; step(2); cpu_rd = 1'b0;
    chk(!err_udr, "R12", "read ignored in transmit", err_udr, 0);
    for (int i = 0; i < 300 && fifo_empty != 2'b11; i++) step();
    step(10);

    // receive with flow control
    flush();
    dir_rx = 1'b1; mask = 2'b01; xfer_en = 1'b1;
    for (int i = 0; i < 300 && fifo_full != 2'b11; i++) step();
    step(10); r0 = rises; step(30);
    chk(rises == r0, "R7", "stopped with both full", rises - r0, 0);
    chk(fifo_full == 2'b11, "R3", "both full", fifo_full, 3);
    chk(irq_full == 2'b10, "R4", "masked irq", irq_full, 2);
    for (int i = 0; i < 5; i++) rd_byte();
    r0 = rises; step(20);
    chk(rises == r0, "R7", "no restart on partial drain", rises - r0, 0);
    for (int i = 0; i < 3; i++) rd_byte();
    r0 = rises; step(15);
    chk(rises > r0, "R7", "restart once fifo0 empty", rises - r0, 1);
    for (int i = 0; i < 30; i++) rd_byte();
    chk(err_udr == 1'b1, "R11", "underrun after long read burst", err_udr, 1);
    cpu_wr = 1'b1; step(3); cpu_wr = 1'b0;
    chk(!err_ovr, "R12", "write ignored in receive", err_ovr, 0);
    step(20);

    // flow control off, receive
    flush();
    flow_en = 1'b0; xfer_en = 1'b1;
    step(120);
    chk(fifo_full == 2'b11, "R12", "extra card bytes dropped", fifo_full, 3);
    r0 = rises; step(40);
    chk(rises - r0 == 40 / (2 * DIV), "R8", "free-run rises in receive", rises - r0, 40 / (2 * DIV));

    // flow control off, transmit
    flush();
    dir_rx = 1'b0; xfer_en = 1'b1;
    step(5); r0 = rises; step(40);
    chk(rises - r0 == 40 / (2 * DIV), "R8", "free-run rises in transmit", rises - r0, 40 / (2 * DIV));
    chk(fifo_empty == 2'b11, "R12", "card reads from empty dropped", fifo_empty, 3);
    step(1); flow_en = 1'b1;
    step(6); r0 = rises; step(20);
    chk(rises == r0, "R9", "stops after flow enabled", rises - r0, 0);
    chk(card_clk == 1'b0, "R9", "stopped low", card_clk, 0);

    step(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule